// File: doc/BRIEF.md
# Bit-Slip Word Realigner

This block turns one serial lane into parallel words of a fixed width and lets the word boundary be moved one bit at a time. Serial bits arrive on `ser_din`, one bit per rising edge of `ser_clk`. They are packed into words of `FACTOR` bits. The earliest bit of each word sits at the highest index. A one-cycle `word_valid` strobe marks each new word.

A chip instantiates one realigner per receive lane. Each lane has its own slip control. Logic in the parallel-clock domain decides when a lane should slip. It raises `slip_req` to move that lane's boundary one bit later in the stream, which adds one bit of latency between the line and the word output. Only the rising edge counts. The edge is found on `par_clk` and handed to the serial domain through a toggle synchroniser. There it becomes a single-cycle slip event, which makes the word counter skip one advance.

The output side carries a valid strobe and no ready. A serial lane cannot be paused, so there is no back-pressure. The consumer must accept every word in the cycle its strobe is high. The next word follows no sooner than `FACTOR` serial cycles later.

Top module: `bitslip_realigner`

## Requirements
- R1: While `rst_n` is low, `word_valid` is 0 and `word_out` is all zeros. In the first serial cycle after reset release, `word_valid` stays 0. Counting from 0 with the first bit sampled after release, the first word ends on bit FACTOR-1.
- R2: With no slip pending, `word_valid` is high for exactly one serial cycle. Consecutive strobes are exactly FACTOR serial cycles apart.
- R3: When `word_valid` is high, `word_out` holds the last FACTOR sampled bits. The earliest bit is at index FACTOR-1 and the latest at index 0. The latest bit is the one sampled on the edge that raised the strobe.
- R4: A rising edge of `slip_req`, sampled on `par_clk`, produces exactly one slip. The word after the slip ends one bit later than it would have, so that gap is FACTOR+1 serial cycles. No bit is lost from any word.
- R5: Holding `slip_req` high for several parallel-clock periods after its rising edge causes no further slip.
- R6: Two requests both take effect when each is high for one parallel-clock period and they are separated by one parallel-clock period low.
- R7: After FACTOR slips, the word boundary is back at its position after reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| ser_clk | input | 1 | Serial bit clock |
| par_clk | input | 1 | Parallel-domain clock of the slip requester |
| rst_n | input | 1 | Asynchronous active-low reset for both domains |
| ser_din | input | 1 | Serial data bit, sampled on rising `ser_clk` |
| slip_req | input | 1 | Slip request level; its rising edge slips one bit |
| word_out | output | FACTOR | Parallel word, earliest bit at the top index |
| word_valid | output | 1 | One-cycle strobe marking a new word |

## Verification
A word is due in the serial cycle after the edge that sampled its last bit. The bench therefore reads the outputs at the falling edge, after the bit it has just handed over. It rebuilds each expected word from its own copy of the bit stream. The boundary is derived from the index of the last bit. A slip reaches the serial domain a few serial cycles after the sampling `par_clk` edge, and that delay is not fixed to the cycle. Each request therefore pushes its expected new boundary into a queue. Any word may take the head of the queue, but only with a gap of exactly FACTOR+1. Every other word must keep the current boundary with a gap of exactly FACTOR.

// File: rtl/bitslip_pkg.sv
package bitslip_pkg;
  localparam int unsigned BS_MIN_FACTOR = 4;
  localparam int unsigned BS_MAX_FACTOR = 10;
  localparam int unsigned BS_DEF_FACTOR = 8;
  localparam int unsigned BS_DEF_SYNC   = 2;

  function automatic int unsigned bs_cnt_width(input int unsigned factor);
    return (factor <= 2) ? 1 : $clog2(factor);
  endfunction
endpackage

// File: rtl/bitslip_req_edge.sv
module bitslip_req_edge (
  input  logic par_clk,
  input  logic rst_n,
  input  logic slip_req,
  output logic slip_tog
);
  logic req_q;
  logic req_rise;

  assign req_rise = slip_req & ~req_q;

  always_ff @(posedge par_clk or negedge rst_n) begin
    if (!rst_n) begin
      req_q    <= 1'b0;
      slip_tog <= 1'b0;
    end else begin
      req_q <= slip_req;
      if (req_rise) slip_tog <= ~slip_tog;
    end
  end

  // R4: a newly seen high level flips the toggle once
  p_rise_flips_r4: assert property (@(posedge par_clk) disable iff (!rst_n)
    (slip_req && !req_q) |=> (slip_tog != $past(slip_tog)));

  // R5: a level held high leaves the toggle alone
  p_hold_no_flip_r5: assert property (@(posedge par_clk) disable iff (!rst_n)
    (slip_req && req_q) |=> $stable(slip_tog));
endmodule

// File: rtl/bitslip_sync.sv
module bitslip_sync #(
  parameter int unsigned STAGES = bitslip_pkg::BS_DEF_SYNC
) (
  input  logic ser_clk,
  input  logic rst_n,
  input  logic tog_in,
  output logic slip_evt
);
  localparam int unsigned DEPTH = STAGES + 1;

  logic [DEPTH-1:0] chain;

  always_ff @(posedge ser_clk or negedge rst_n) begin
    if (!rst_n) chain <= '0;
    else        chain <= {chain[DEPTH-2:0], tog_in};
  end

  assign slip_evt = chain[DEPTH-1] ^ chain[DEPTH-2];

  // R6: requests spaced by the low-time rule arrive as separate one-cycle events
  p_evt_single_r6: assert property (@(posedge ser_clk) disable iff (!rst_n)
    slip_evt |=> !slip_evt);
endmodule

// File: rtl/bitslip_deser.sv
module bitslip_deser #(
  parameter int unsigned FACTOR = bitslip_pkg::BS_DEF_FACTOR
) (
  input  logic              ser_clk,
  input  logic              rst_n,
  input  logic              ser_din,
  input  logic              slip_evt,
  output logic [FACTOR-1:0] word_out,
  output logic              word_valid
);
  localparam int unsigned         CW   = bitslip_pkg::bs_cnt_width(FACTOR);
  localparam logic [CW-1:0]       LAST = CW'(FACTOR - 1);

  logic [FACTOR-2:0] shreg;
  logic [CW-1:0]     bit_cnt;

  always_ff @(posedge ser_clk or negedge rst_n) begin
    if (!rst_n) begin
      shreg      <= '0;
      bit_cnt    <= '0;
      word_out   <= '0;
      word_valid <= 1'b0;
    end else begin
      shreg <= {shreg[FACTOR-3:0], ser_din};
      if (slip_evt) begin
        word_valid <= 1'b0;
      end else if (bit_cnt == LAST) begin
        bit_cnt    <= '0;
        word_out   <= {shreg, ser_din};
        word_valid <= 1'b1;
      end else begin
        bit_cnt    <= bit_cnt + 1'b1;
        word_valid <= 1'b0;
      end
    end
  end

  // R3: the newest bit of a fresh word is the one just sampled
  p_newest_bit_r3: assert property (@(posedge ser_clk) disable iff (!rst_n)
    word_valid |-> (word_out[0] == $past(ser_din)));

  // R2: the word strobe lasts one serial cycle
  p_strobe_single_r2: assert property (@(posedge ser_clk) disable iff (!rst_n)
    word_valid |=> !word_valid);
endmodule

// File: rtl/bitslip_realigner.sv
module bitslip_realigner #(
  parameter int unsigned FACTOR      = bitslip_pkg::BS_DEF_FACTOR,
  parameter int unsigned SYNC_STAGES = bitslip_pkg::BS_DEF_SYNC
) (
  input  logic              ser_clk,
  input  logic              par_clk,
  input  logic              rst_n,
  input  logic              ser_din,
  input  logic              slip_req,
  output logic [FACTOR-1:0] word_out,
  output logic              word_valid
);
  logic slip_tog;
  logic slip_evt;

  bitslip_req_edge u_edge (
    .par_clk  (par_clk),
    .rst_n    (rst_n),
    .slip_req (slip_req),
    .slip_tog (slip_tog)
  );

  bitslip_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .ser_clk  (ser_clk),
    .rst_n    (rst_n),
    .tog_in   (slip_tog),
    .slip_evt (slip_evt)
  );

  bitslip_deser #(.FACTOR(FACTOR)) u_deser (
    .ser_clk    (ser_clk),
    .rst_n      (rst_n),
    .ser_din    (ser_din),
    .slip_evt   (slip_evt),
    .word_out   (word_out),
    .word_valid (word_valid)
  );

  // R1: no word in the first serial cycle after reset release
  p_quiet_after_reset_r1: assert property (@(posedge ser_clk) disable iff (!rst_n)
    $past(!rst_n) |-> !word_valid);
endmodule

// File: tb/test_bitslip_realigner.sv
module test_bitslip_realigner;
  localparam int CLK_PERIOD = 10;
  localparam int FACTOR     = 8;
  localparam int NBITS      = 4096;

  logic              ser_clk = 1'b0;
  logic              par_clk = 1'b0;
  logic              rst_n   = 1'b0;
  logic              ser_din = 1'b0;
  logic              slip_req = 1'b0;
  logic [FACTOR-1:0] word_out;
  logic              word_valid;

  always #(CLK_PERIOD/2) ser_clk = ~ser_clk;
  always #(CLK_PERIOD*FACTOR/2) par_clk = ~par_clk;

  bitslip_realigner #(.FACTOR(FACTOR)) i_bitslip_realigner (
    .ser_clk    (ser_clk),
    .par_clk    (par_clk),
    .rst_n      (rst_n),
    .ser_din    (ser_din),
    .slip_req   (slip_req),
    .word_out   (word_out),
    .word_valid (word_valid)
  );

  int   n_chk = 0;
  int   n_fail = 0;
  logic sbits [NBITS];
  int   nbits = 0;
  int   q_off [$];
  int   cur_off = 0;
  int   push_off = 0;
  int   prev_last = -1;
  int   n_words = 0;
  bit   done = 1'b0;

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // monitor and serial driver, both on the falling edge
  always @(negedge ser_clk) begin : serial_side
    int last;
    int off;
    logic [FACTOR-1:0] expw;
    if (rst_n && !done) begin
      if (word_valid) begin
        last = nbits - 1;
        for (int i = 0; i < FACTOR; i++) expw[FACTOR-1-i] = sbits[last-FACTOR+1+i];
        chk(word_out === expw, "R3 word contents", word_out, expw);
        off = (last + 1) % FACTOR;
        if (prev_last < 0) begin
          chk(off == cur_off, "R1 first boundary", off, cur_off);
        end else if (off == cur_off) begin
          chk(last - prev_last == FACTOR, "R2 word spacing", last - prev_last, FACTOR);
        end else if (q_off.size() > 0 && off == q_off[0]) begin
          void'(q_off.pop_front());
          cur_off = off;
          chk(last - prev_last == FACTOR + 1, "R4 one-bit delay", last - prev_last, FACTOR + 1);
        end else begin
          chk(1'b0, "R5 unexpected boundary", off, cur_off);
        end
        prev_last = last;
        n_words++;
      end
      if (nbits < NBITS) ser_din = sbits[nbits];
      nbits++;
    end
  end

  task automatic slip(input int high, input int low);
    @(negedge par_clk);
    slip_req = 1'b1;
    push_off = (push_off + 1) % FACTOR;
    q_off.push_back(push_off);
    repeat (high) @(negedge par_clk);
    slip_req = 1'b0;
    repeat (low - 1) @(negedge par_clk);
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
  endtask

  initial begin : main
    logic [15:0] lfsr;
    lfsr = 16'hACE1;
    for (int i = 0; i < NBITS; i++) begin
      sbits[i] = lfsr[0];
      lfsr = {lfsr[0] ^ lfsr[2] ^ lfsr[3] ^ lfsr[5], lfsr[15:1]};
    end

    repeat (3) @(posedge ser_clk);
    #1;
    chk(word_valid === 1'b0, "R1 reset valid", word_valid, 0);
    chk(word_out === '0, "R1 reset word", word_out, 0);
    @(posedge ser_clk);
    #(CLK_PERIOD/4) rst_n = 1'b1;

    repeat (4) @(negedge par_clk);
    slip(1, 6);                 // R4 single minimum-width request
    slip(10, 6);                // R5 level held high for ten periods
    slip(1, 1);                 // R6 minimum low time between requests
    slip(1, 6);
    for (int k = 0; k < 4; k++) slip(1, 6);
    repeat (6) @(negedge par_clk);

    chk(q_off.size() == 0, "R6 all requests applied", q_off.size(), 0);
    chk(cur_off == 0, "R7 boundary wrap after FACTOR slips", cur_off, 0);
    chk(n_words >= nbits / (FACTOR + 1) - 1, "R2 word count", n_words, nbits / (FACTOR + 1) - 1);
    done = 1'b1;
    summary();
    $finish;
  end

  initial begin : watchdog
    #(CLK_PERIOD * 200000);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      summary();
      $finish;
    end
  end
endmodule